// File: doc/BRIEF.md
# Multi-Cycle Accumulator Processor

This block is a small stored-program processor built around a single 16-bit accumulator. Instructions and data share one 4096-word internal memory, addressed by the word, that holds 16-bit two's complement values. Each instruction is fetched into an instruction register, decoded, and carried out as a short series of register-transfer steps. In each step one source drives a common internal bus and one or more registers or the memory take the value from it.

The instruction set covers direct and pointer-based loads, stores and adds, subtraction, a conditional skip, plain and pointer jumps, a subroutine call that leaves its return address in memory, clearing the accumulator, polled byte input, byte output and halt. While reset is held, the surrounding logic fills the memory through a write port. After reset is released, execution starts at address 0 and runs until a halt instruction.

Top module: `acc_cpu`

## Requirements
- R1: While `rst` is high, AC, PC, `out_data` and `out_valid` are cleared and `halted` is low. After release, the first instruction is fetched from address 0.
- R2: An instruction word carries its opcode in bits 15:12 and an operand address X in bits 11:0. The opcodes are 0 call, 1 load, 2 store, 3 add, 4 subtract, 5 input, 6 output, 7 halt, 8 skip, 9 jump, A clear, B add indirect, C jump indirect, D load indirect and E store indirect. Opcode F does nothing.
- R3: Load sets AC to M[X]. Add sets AC to AC+M[X] and subtract sets AC to AC−M[X], both wrapping modulo 2^16. Store writes AC to M[X]. Clear sets AC to 0.
- R4: Skip tests AC as a signed value using bits 11:10: 00 tests AC<0, 01 tests AC=0, 10 tests AC>0. When the test holds, the next instruction is passed over. Code 11 never skips.
- R5: The indirect load, add and store read the pointer P=M[X] first, then use M[P[11:0]] as their operand or target.
- R6: Jump sets PC to X. Jump indirect sets PC to M[X][11:0].
- R7: Call stores the address of the instruction that follows it into M[X], then continues at X+1.
- R8: Input waits with AC unchanged while `in_valid` is low. Once `in_valid` is high, AC takes the sign extension of `in_data`.
- R9: Output places AC[7:0] on `out_data` and raises `out_valid` for exactly one cycle per output instruction.
- R10: Halt raises `halted` and holds it. PC stays at the address after the halt instruction, and no further output occurs until reset.
- R11: Counting from the release of reset, these cycle costs apply. Clear, output, skip, jump and halt take 3 cycles. Direct load, store, add, subtract and jump indirect take 5. Indirect load, add and store and the call take 7. `halted` is high after the sum of the costs, including that of the halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Memory preload write enable, used while in reset |
| load_addr | input | 12 | Preload word address |
| load_data | input | 16 | Preload word value |
| in_data | input | 8 | Input byte presented to the processor |
| in_valid | input | 1 | Input byte is available |
| out_data | output | 8 | Output register |
| out_valid | output | 1 | One-cycle strobe for a new output byte |
| halted | output | 1 | Processor has executed halt |
| acc_q | output | 16 | Accumulator value |
| pc_q | output | 12 | Program counter value |

## Verification
Random straight-line programs mix direct loads, adds, subtracts, stores, clears and outputs over random data. Comparing the final accumulator, the output stream and the cycle count against a model separates wrong arithmetic, lost stores and wrong step counts. Directed programs cover the rest. Every skip code is tried against negative, zero and positive accumulators, which sets apart the sign and zero tests and the never-skip code. Pointer chains show whether an indirect operand comes from the pointer or from X. Nested calls and returns check the stored return address. An input that is withheld and then supplied, with a negative byte, shows the wait and the sign extension.

// File: rtl/acc_cpu_pkg.sv
`timescale 1ns/1ps
package acc_cpu_pkg;
    localparam int WORD_W = 16;
    localparam int ADDR_W = 12;
    localparam int IO_W   = 8;
    localparam int OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_CALL   = 4'h0, OP_LOAD  = 4'h1, OP_STORE  = 4'h2, OP_ADD    = 4'h3,
        OP_SUB    = 4'h4, OP_IN    = 4'h5, OP_OUT    = 4'h6, OP_HALT   = 4'h7,
        OP_SKIP   = 4'h8, OP_JUMP  = 4'h9, OP_CLEAR  = 4'hA, OP_ADDP   = 4'hB,
        OP_JUMPP  = 4'hC, OP_LOADP = 4'hD, OP_STOREP = 4'hE, OP_NOP    = 4'hF
    } opcode_e;

    typedef enum logic [3:0] {
        ST_F0, ST_F1, ST_DEC, ST_RD, ST_IND, ST_RD2, ST_EXE,
        ST_WB, ST_WR, ST_CL1, ST_CL2, ST_CL3, ST_CL4, ST_HALT
    } state_e;

    typedef enum logic [2:0] {
        BUS_NONE, BUS_PC, BUS_IR, BUS_MBR, BUS_AC, BUS_MEM
    } bus_src_e;

    typedef enum logic [2:0] {
        AC_HOLD, AC_LD, AC_ADD, AC_SUB, AC_CLR, AC_IN
    } ac_op_e;

    typedef struct packed {
        bus_src_e bus_src;
        logic     ld_mar;
        logic     ld_mbr;
        logic     ld_ir;
        logic     ld_pc;
        logic     pc_inc;
        ac_op_e   ac_op;
        logic     mem_we;
        logic     out_we;
    } ctl_t;

    function automatic logic skip_taken(input logic [1:0] cc, input logic [WORD_W-1:0] ac);
        logic neg, zero;
        neg  = ac[WORD_W-1];
        zero = (ac == '0);
        case (cc)
            2'b00:   return neg;
            2'b01:   return zero;
            2'b10:   return !neg && !zero;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] ac_next(input ac_op_e op,
                                                  input logic [WORD_W-1:0] ac,
                                                  input logic [WORD_W-1:0] mbr,
                                                  input logic [IO_W-1:0] din);
        case (op)
            AC_LD:   return mbr;
            AC_ADD:  return ac + mbr;
            AC_SUB:  return ac - mbr;
            AC_CLR:  return '0;
            AC_IN:   return {{(WORD_W-IO_W){din[IO_W-1]}}, din};
            default: return ac;
        endcase
    endfunction
endpackage

// File: rtl/acc_cpu_mem.sv
`timescale 1ns/1ps
module acc_cpu_mem #(
    parameter int AW = 12,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic [AW-1:0] rd_addr,
    input  logic          we,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store_q[wr_addr] <= wdata;
        rdata <= store_q[rd_addr];
    end
endmodule

// File: rtl/acc_cpu_ctrl.sv
`timescale 1ns/1ps
module acc_cpu_ctrl
    import acc_cpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [5:0]        ir_hi,
    input  logic [WORD_W-1:0] acc,
    input  logic              in_valid,
    output ctl_t              ctl,
    output state_e            state_q
);
    opcode_e op;
    logic [1:0] cc;
    state_e state_d;

    assign op = opcode_e'(ir_hi[5:2]);
    assign cc = ir_hi[1:0];

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_F0;
        else     state_q <= state_d;
    end

    always_comb begin
        ctl     = '0;
        state_d = state_q;
        unique case (state_q)
            ST_F0: begin
                ctl.bus_src = BUS_PC;
                ctl.ld_mar  = 1'b1;
                state_d     = ST_F1;
            end
            ST_F1: begin
                ctl.bus_src = BUS_MEM;
                ctl.ld_ir   = 1'b1;
                ctl.pc_inc  = 1'b1;
                state_d     = ST_DEC;
            end
            ST_DEC: begin
                case (op)
                    OP_LOAD, OP_STORE, OP_ADD, OP_SUB,
                    OP_ADDP, OP_JUMPP, OP_LOADP, OP_STOREP: begin
                        ctl.bus_src = BUS_IR;
                        ctl.ld_mar  = 1'b1;
                        state_d     = (op == OP_STORE) ? ST_WB : ST_RD;
                    end
                    OP_CALL: begin
                        ctl.bus_src = BUS_PC;
                        ctl.ld_mbr  = 1'b1;
                        state_d     = ST_CL1;
                    end
                    OP_IN: begin
                        if (in_valid) begin
                            ctl.ac_op = AC_IN;
                            state_d   = ST_F0;
                        end
                    end
                    OP_OUT: begin
                        ctl.out_we = 1'b1;
                        state_d    = ST_F0;
                    end
                    OP_HALT: state_d = ST_HALT;
                    OP_SKIP: begin
                        ctl.pc_inc = skip_taken(cc, acc);
                        state_d    = ST_F0;
                    end
                    OP_JUMP: begin
                        ctl.bus_src = BUS_IR;
                        ctl.ld_pc   = 1'b1;
                        state_d     = ST_F0;
                    end
                    OP_CLEAR: begin
                        ctl.ac_op = AC_CLR;
                        state_d   = ST_F0;
                    end
                    default: state_d = ST_F0;
                endcase
            end
            ST_RD: begin
                ctl.bus_src = BUS_MEM;
                ctl.ld_mbr  = 1'b1;
                state_d = (op == OP_LOAD || op == OP_ADD || op == OP_SUB) ? ST_EXE : ST_IND;
            end
            ST_IND: begin
                ctl.bus_src = BUS_MBR;
                if (op == OP_JUMPP) begin
                    ctl.ld_pc = 1'b1;
                    state_d   = ST_F0;
                end else begin
                    ctl.ld_mar = 1'b1;
                    state_d    = (op == OP_STOREP) ? ST_WB : ST_RD2;
                end
            end
            ST_RD2: begin
                ctl.bus_src = BUS_MEM;
                ctl.ld_mbr  = 1'b1;
                state_d     = ST_EXE;
            end
            ST_EXE: begin
                case (op)
                    OP_LOAD, OP_LOADP: ctl.ac_op = AC_LD;
                    OP_ADD, OP_ADDP:   ctl.ac_op = AC_ADD;
                    OP_SUB:            ctl.ac_op = AC_SUB;
                    default:           ctl.ac_op = AC_HOLD;
                endcase
                state_d = ST_F0;
            end
            ST_WB: begin
                ctl.bus_src = BUS_AC;
                ctl.ld_mbr  = 1'b1;
                state_d     = ST_WR;
            end
            ST_WR: begin
                ctl.mem_we = 1'b1;
                state_d    = ST_F0;
            end
            ST_CL1: begin
                ctl.bus_src = BUS_IR;
                ctl.ld_mar  = 1'b1;
                state_d     = ST_CL2;
            end
            ST_CL2: begin
                ctl.mem_we = 1'b1;
                state_d    = ST_CL3;
            end
            ST_CL3: begin
                ctl.bus_src = BUS_IR;
                ctl.ld_pc   = 1'b1;
                state_d     = ST_CL4;
            end
            ST_CL4: begin
                ctl.pc_inc = 1'b1;
                state_d    = ST_F0;
            end
            ST_HALT: state_d = ST_HALT;
            default: state_d = ST_F0;
        endcase
    end
endmodule

// File: rtl/acc_cpu_dp.sv
`timescale 1ns/1ps
module acc_cpu_dp
    import acc_cpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ctl_t              ctl,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic [IO_W-1:0]   in_data,
    output logic [ADDR_W-1:0] mem_raddr,
    output logic [ADDR_W-1:0] mar_q,
    output logic [WORD_W-1:0] mbr_q,
    output logic [WORD_W-1:0] ir_q,
    output logic [WORD_W-1:0] acc_q,
    output logic [ADDR_W-1:0] pc_q,
    output logic [IO_W-1:0]   out_data,
    output logic              out_valid
);
    logic [WORD_W-1:0] bus;

    always_comb begin
        unique case (ctl.bus_src)
            BUS_PC:  bus = {{(WORD_W-ADDR_W){1'b0}}, pc_q};
            BUS_IR:  bus = {{(WORD_W-ADDR_W){1'b0}}, ir_q[ADDR_W-1:0]};
            BUS_MBR: bus = mbr_q;
            BUS_AC:  bus = acc_q;
            BUS_MEM: bus = mem_rdata;
            default: bus = '0;
        endcase
    end

    // the memory sees the address being loaded so its registered read is ready next step
    assign mem_raddr = ctl.ld_mar ? bus[ADDR_W-1:0] : mar_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mar_q     <= '0;
            mbr_q     <= '0;
            ir_q      <= '0;
            acc_q     <= '0;
            pc_q      <= '0;
            out_data  <= '0;
            out_valid <= 1'b0;
        end else begin
            if (ctl.ld_mar) mar_q <= bus[ADDR_W-1:0];
            if (ctl.ld_mbr) mbr_q <= bus;
            if (ctl.ld_ir)  ir_q  <= bus;
            if (ctl.ld_pc)       pc_q <= bus[ADDR_W-1:0];
            else if (ctl.pc_inc) pc_q <= pc_q + 1'b1;
            acc_q <= ac_next(ctl.ac_op, acc_q, mbr_q, in_data);
            if (ctl.out_we) out_data <= acc_q[IO_W-1:0];
            out_valid <= ctl.out_we;
        end
    end
endmodule

// File: rtl/acc_cpu.sv
`timescale 1ns/1ps
module acc_cpu
    import acc_cpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [WORD_W-1:0] load_data,
    input  logic [IO_W-1:0]   in_data,
    input  logic              in_valid,
    output logic [IO_W-1:0]   out_data,
    output logic              out_valid,
    output logic              halted,
    output logic [WORD_W-1:0] acc_q,
    output logic [ADDR_W-1:0] pc_q
);
    ctl_t              ctl;
    state_e            state_q;
    logic [ADDR_W-1:0] mem_raddr;
    logic [ADDR_W-1:0] mar_q;
    logic [WORD_W-1:0] mbr_q;
    logic [WORD_W-1:0] ir_q;
    logic [WORD_W-1:0] mem_rdata;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [WORD_W-1:0] mem_wdata;

    acc_cpu_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .ir_hi    (ir_q[WORD_W-1:ADDR_W-2]),
        .acc      (acc_q),
        .in_valid (in_valid),
        .ctl      (ctl),
        .state_q  (state_q)
    );

    acc_cpu_dp u_dp (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .mem_rdata (mem_rdata),
        .in_data   (in_data),
        .mem_raddr (mem_raddr),
        .mar_q     (mar_q),
        .mbr_q     (mbr_q),
        .ir_q      (ir_q),
        .acc_q     (acc_q),
        .pc_q      (pc_q),
        .out_data  (out_data),
        .out_valid (out_valid)
    );

    assign mem_we    = load_en | ctl.mem_we;
    assign mem_waddr = load_en ? load_addr : mar_q;
    assign mem_wdata = load_en ? load_data : mbr_q;

    acc_cpu_mem #(.AW(ADDR_W), .DW(WORD_W)) u_mem (
        .clk     (clk),
        .rd_addr (mem_raddr),
        .we      (mem_we),
        .wr_addr (mem_waddr),
        .wdata   (mem_wdata),
        .rdata   (mem_rdata)
    );

    assign halted = (state_q == ST_HALT);
endmodule

// File: rtl/acc_cpu_chk.sv
`timescale 1ns/1ps
module acc_cpu_chk
    import acc_cpu_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input state_e            state,
    input logic [5:0]        ir_hi,
    input logic [WORD_W-1:0] acc,
    input logic [ADDR_W-1:0] pc,
    input logic              halted,
    input logic              out_valid,
    input logic              in_valid
);
    logic dec_in, dec_skip_never;
    assign dec_in         = (state == ST_DEC) && (ir_hi[5:2] == 4'h5);
    assign dec_skip_never = (state == ST_DEC) && (ir_hi[5:2] == 4'h8) && (ir_hi[1:0] == 2'b11);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pc == '0 && acc == '0 && !halted && !out_valid));

    // R10
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && $stable(pc) && !out_valid));

    // R9
    out_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R8
    input_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (dec_in && !in_valid) |=> ($stable(acc) && state == ST_DEC));

    // R4
    skip_never_chk: assert property (@(posedge clk) disable iff (rst)
        dec_skip_never |=> $stable(pc));
endmodule

bind acc_cpu acc_cpu_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .state     (state_q),
    .ir_hi     (ir_q[15:10]),
    .acc       (acc_q),
    .pc        (pc_q),
    .halted    (halted),
    .out_valid (out_valid),
    .in_valid  (in_valid)
);

// File: tb/acc_cpu_bench.sv
`timescale 1ns/1ps
module acc_cpu_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_en = 1'b0;
    logic [11:0] load_addr = '0;
    logic [15:0] load_data = '0;
    logic [7:0]  in_data = '0;
    logic        in_valid = 1'b0;
    logic [7:0]  out_data;
    logic        out_valid;
    logic        halted;
    logic [15:0] acc_q;
    logic [11:0] pc_q;

    int total = 0;
    int bad = 0;
    logic [7:0] outs [64];
    int n_out = 0;

    always #2.5 clk = ~clk;

    acc_cpu u_acc_cpu (
        .clk(clk), .rst(rst), .load_en(load_en), .load_addr(load_addr),
        .load_data(load_data), .in_data(in_data), .in_valid(in_valid),
        .out_data(out_data), .out_valid(out_valid), .halted(halted),
        .acc_q(acc_q), .pc_q(pc_q)
    );

    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (n_out < 64) outs[n_out] = out_data;
            n_out = n_out + 1;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic prog_begin();
        @(negedge clk);
        rst = 1'b1;
        n_out = 0;
    endtask

    task automatic w(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        load_en = 1'b1;
        load_addr = a;
        load_data = d;
    endtask

    task automatic go();
        @(negedge clk);
        load_en = 1'b0;
        rst = 1'b0;
    endtask

    task automatic wait_halt(input int lim, output int cyc);
        cyc = 0;
        while (!halted && cyc < lim) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
        end
        if (!halted) chk("R10", "halt reached", 0, 1);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        summary();
        $finish;
    end

    // R3 R9 R11: random straight-line program against a bench model
    task automatic random_trial();
        logic [15:0] d [8];
        logic [15:0] ac;
        logic [7:0]  eo [16];
        int ne, ecyc, cyc;
        ac = '0; ne = 0; ecyc = 0;
        prog_begin();
        for (int i = 0; i < 8; i++) begin
            d[i] = 16'($urandom);
            w(12'h900 + 12'(i), d[i]);
        end
        for (int k = 0; k < 12; k++) begin
            int sel, idx;
            sel = int'($urandom % 6);
            idx = int'($urandom % 8);
            case (sel)
                0: begin w(12'(k), {4'h1, 12'h900 + 12'(idx)}); ac = d[idx]; ecyc += 5; end
                1: begin w(12'(k), {4'h3, 12'h900 + 12'(idx)}); ac = ac + d[idx]; ecyc += 5; end
                2: begin w(12'(k), {4'h4, 12'h900 + 12'(idx)}); ac = ac - d[idx]; ecyc += 5; end
                3: begin w(12'(k), {4'h2, 12'h900 + 12'(idx)}); d[idx] = ac; ecyc += 5; end
                4: begin w(12'(k), 16'hA000); ac = '0; ecyc += 3; end
                default: begin w(12'(k), 16'h6000); eo[ne] = ac[7:0]; ne++; ecyc += 3; end
            endcase
        end
        w(12'd12, 16'h7000);
        ecyc += 3;
        go();
        wait_halt(2000, cyc);
        chk("R3", "random acc", acc_q, ac);
        chk("R11", "random cycles", cyc, ecyc);
        chk("R9", "random output count", n_out, ne);
        for (int i = 0; i < ne; i++) chk("R9", "random output byte", outs[i], eo[i]);
    endtask

    initial begin
        int cyc;
        logic [15:0] vals [3];
        vals[0] = 16'h8001; vals[1] = 16'h0000; vals[2] = 16'h1234;
        void'($urandom(32'h5eed_0001));

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "reset pc", pc_q, 0);
        chk("R1", "reset acc", acc_q, 0);
        chk("R1", "reset halted", halted, 0);
        chk("R1", "reset out_valid", out_valid, 0);
        chk("R1", "reset out_data", out_data, 0);

        for (int t = 0; t < 6; t++) random_trial();

        // R4: every skip code against negative, zero and positive AC
        for (int cc = 0; cc < 4; cc++) begin
            for (int v = 0; v < 3; v++) begin
                logic take;
                take = (cc == 0 && v == 0) || (cc == 1 && v == 1) || (cc == 2 && v == 2);
                prog_begin();
                w(12'h020, vals[v]);
                w(12'h021, 16'h0055);
                w(12'h000, 16'h1020);
                w(12'h001, 16'h8000 | 16'(cc << 10));
                w(12'h002, 16'h1021);
                w(12'h003, 16'h7000);
                go();
                wait_halt(200, cyc);
                chk("R4", "skip result", acc_q, take ? vals[v] : 16'h0055);
            end
        end

        // R5 R11: pointer chain load, add, store
        prog_begin();
        w(12'h030, 16'h0040); w(12'h031, 16'h0041); w(12'h032, 16'h0042);
        w(12'h040, 16'h0123); w(12'h041, 16'h0010); w(12'h042, 16'hDEAD);
        w(12'h000, 16'hD030); w(12'h001, 16'hB031); w(12'h002, 16'hE032);
        w(12'h003, 16'hA000); w(12'h004, 16'h1042); w(12'h005, 16'h7000);
        go();
        wait_halt(500, cyc);
        chk("R5", "indirect chain acc", acc_q, 16'h0133);
        chk("R11", "indirect cycles", cyc, 32);

        // R6: pointer jump then direct jump
        prog_begin();
        w(12'h021, 16'h0055); w(12'h033, 16'h0060); w(12'h034, 16'h0777);
        w(12'h000, 16'hC033); w(12'h001, 16'h1021); w(12'h002, 16'h7000);
        w(12'h060, 16'hA000); w(12'h061, 16'h3034); w(12'h062, 16'h9070);
        w(12'h070, 16'h4021); w(12'h071, 16'h7000);
        go();
        wait_halt(500, cyc);
        chk("R6", "jump acc", acc_q, 16'h0722);
        chk("R6", "jump pc", pc_q, 12'h072);

        // R7 R9 R10: call stores return address, output it, halt holds
        prog_begin();
        w(12'h000, 16'h0010); w(12'h001, 16'h7000);
        w(12'h010, 16'hBEEF); w(12'h011, 16'h1010);
        w(12'h012, 16'h6000); w(12'h013, 16'h7000);
        go();
        wait_halt(500, cyc);
        chk("R7", "return address", acc_q, 16'h0001);
        chk("R9", "output byte", outs[0], 8'h01);
        chk("R10", "halt pc", pc_q, 12'h014);
        repeat (8) @(negedge clk);
        chk("R10", "halt pc frozen", pc_q, 12'h014);
        chk("R10", "halt held", halted, 1);
        chk("R10", "no output after halt", n_out, 1);

        // R1: reset clears a halted machine
        prog_begin();
        w(12'h000, 16'h0300);
        @(negedge clk);
        chk("R1", "reset clears halted", halted, 0);
        chk("R1", "reset clears pc", pc_q, 0);

        // R7 R11: call and return through a pointer jump
        w(12'h000, 16'h9205); w(12'h205, 16'h0300); w(12'h206, 16'h7000);
        w(12'h301, 16'h1300); w(12'h302, 16'hC300);
        go();
        wait_halt(500, cyc);
        chk("R7", "return to caller acc", acc_q, 16'h0206);
        chk("R7", "return to caller pc", pc_q, 12'h207);
        chk("R11", "call cycles", cyc, 23);

        // R8: input withheld then supplied with a negative byte
        prog_begin();
        w(12'h021, 16'h0055);
        w(12'h000, 16'h1021); w(12'h001, 16'h5000);
        w(12'h002, 16'h6000); w(12'h003, 16'h7000);
        go();
        repeat (25) @(negedge clk);
        chk("R8", "acc while waiting", acc_q, 16'h0055);
        chk("R8", "no output while waiting", n_out, 0);
        in_data = 8'h9C;
        in_valid = 1'b1;
        wait_halt(200, cyc);
        in_valid = 1'b0;
        chk("R8", "sign extended input", acc_q, 16'hFF9C);
        chk("R9", "input echoed", outs[0], 8'h9C);

        // R8: positive byte already present
        prog_begin();
        w(12'h000, 16'h5000); w(12'h001, 16'h7000);
        in_data = 8'h7F;
        in_valid = 1'b1;
        go();
        wait_halt(200, cyc);
        in_valid = 1'b0;
        chk("R8", "positive input", acc_q, 16'h007F);
        chk("R11", "input ready cycles", cyc, 6);

        // R2: opcode F does nothing
        prog_begin();
        w(12'h021, 16'h0055);
        w(12'h000, 16'h1021); w(12'h001, 16'hF123); w(12'h002, 16'h7000);
        go();
        wait_halt(200, cyc);
        chk("R2", "unused opcode acc", acc_q, 16'h0055);
        chk("R2", "unused opcode pc", pc_q, 12'h003);

        summary();
        $finish;
    end
endmodule